// File: doc/BRIEF.md
# Banked RAM address mapper

This block turns the 8-bit register-file address issued by a small processor core into a physical data-RAM address. The lower half of the address space (0x00 to 0x7F) is a common region: it reaches the same RAM locations whatever bank is selected. The upper half (0x80 to 0xFF) is a 128-byte window onto one page of banked RAM. Because the page size is a power of two, bank and offset are formed by slicing bits, with no adders or dividers in the mapping path apart from the fixed offset past the common region.

Two independent bank selects exist. Direct accesses use the direct bank register. Indirect accesses use the indirect bank register together with an 8-bit pointer register. The indirect pair can be loaded in one step from a 16-bit linear address into banked memory. Incrementing the pointer carries from the 7-bit offset into the indirect bank, so software can walk an array as one contiguous linear pointer across page boundaries.

All register updates happen at the clock edge. The physical address is a combinational function of the current register contents and the access inputs.

Top module: `bam_top`

## Requirements
- R1: A direct access (`acc_ind`=0) to an address with bit 7 clear gives `phys_addr` = address bits [6:0], whatever the direct bank holds.
- R2: A direct access to an address with bit 7 set gives `phys_addr` = 128 + direct_bank*128 + address bits [6:0].
- R3: An indirect access (`acc_ind`=1) ignores `acc_addr` and uses the pointer register: if pointer bit 7 is set, `phys_addr` = 128 + indirect_bank*128 + pointer bits [6:0]; otherwise `phys_addr` = pointer bits [6:0].
- R4: The direct and indirect bank registers are independent: a write to one (`wr_dbank` or `wr_ibank`, data on `wr_data`) leaves the mapping through the other unchanged.
- R5: `ld_lin` loads the indirect bank with `lin_addr[14:7]` and the pointer with {1, `lin_addr[6:0]`}; `lin_addr[15]` has no effect.
- R6: `ptr_inc` adds one to pointer bits [6:0] and leaves pointer bit 7 as it was; when bits [6:0] wrap from 0x7F to 0x00, pointer bit 7 becomes 1 and the indirect bank increments modulo 256.
- R7: Register writes, loads and increments take effect at the next rising clock edge; an access in the same cycle is mapped with the old values.
- R8: While `rst_n` is low, and afterwards until written, both bank registers and the pointer hold zero.
- R9: Priority in one cycle: `ld_lin` overrides `wr_ptr` and `wr_ibank`, which in turn cancel `ptr_inc`; `wr_ptr` alone writes `wr_data` to the pointer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_ind | input | 1 | 1 selects indirect access through the pointer, 0 direct access |
| acc_addr | input | 8 | Register-file address of a direct access |
| wr_data | input | 8 | Data for the register writes |
| wr_dbank | input | 1 | Write `wr_data` to the direct bank register |
| wr_ibank | input | 1 | Write `wr_data` to the indirect bank register |
| wr_ptr | input | 1 | Write `wr_data` to the pointer register |
| ld_lin | input | 1 | Load the indirect bank and pointer from `lin_addr` |
| lin_addr | input | 16 | Linear address into banked memory |
| ptr_inc | input | 1 | Increment the linear pointer |
| phys_addr | output | 16 | Physical data-RAM address |

## Verification
The assertions take for granted that the control inputs are known (not X) in every cycle after reset and that several register controls may be active at once; they make no assumption of one-hot controls, so the priority rules are checked under any combination. The random stimulus respects this by driving every input to a defined value each cycle, asserting each control independently with low probability so that overlaps of load, write and increment occur regularly. Directed sequences add the wrap of the pointer offset, the wrap of the indirect bank from 255 to 0, a pointer with bit 7 clear, and loads with the top linear bit set.

// File: rtl/bam_pkg.sv
package bam_pkg;
    parameter int ADDR_W = 8;   // register-file address width
    parameter int BANK_W = 8;   // bank register width
    parameter int LIN_W  = 16;  // linear pointer width

    localparam int OFF_W  = ADDR_W - 1;        // offset bits inside a page
    localparam int PHYS_W = BANK_W + ADDR_W;   // common region plus all pages
    localparam int PAGE   = 1 << OFF_W;

    typedef struct packed {
        logic [BANK_W-1:0] dbank;
        logic [BANK_W-1:0] ibank;
        logic [ADDR_W-1:0] ptr;
    } bank_state_t;
endpackage

// File: rtl/bam_regs.sv
module bam_regs
    import bam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              wr_dbank,
    input  logic              wr_ibank,
    input  logic              wr_ptr,
    input  logic              ld_lin,
    input  logic [LIN_W-1:0]  lin_addr,
    input  logic              ptr_inc,
    output bank_state_t       st_q
);
    bank_state_t st_d;
    logic [OFF_W:0] off_sum;
    logic           inc_go;

    always_comb begin
        st_d    = st_q;
        off_sum = {1'b0, st_q.ptr[OFF_W-1:0]} + (OFF_W+1)'(1);
        inc_go  = ptr_inc && !ld_lin && !wr_ptr && !wr_ibank;

        if (wr_dbank) st_d.dbank = wr_data[BANK_W-1:0];

        if (ld_lin) begin
            st_d.ibank = lin_addr[OFF_W+BANK_W-1:OFF_W];
            st_d.ptr   = {1'b1, lin_addr[OFF_W-1:0]};
        end else if (wr_ptr || wr_ibank) begin
            if (wr_ibank) st_d.ibank = wr_data[BANK_W-1:0];
            if (wr_ptr)   st_d.ptr   = wr_data;
        end else if (inc_go) begin
            st_d.ptr[OFF_W-1:0] = off_sum[OFF_W-1:0];
            if (off_sum[OFF_W]) begin
                st_d.ptr[OFF_W] = 1'b1;
                st_d.ibank      = st_q.ibank + BANK_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R5: linear load splits into bank and offset, window bit forced
    assert_lin_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ld_lin |=> (st_q.ibank == $past(lin_addr[OFF_W+BANK_W-1:OFF_W]))
                && (st_q.ptr == {1'b1, $past(lin_addr[OFF_W-1:0])}));

    // R6: offset wrap carries into the indirect bank and stays in the window
    assert_wrap_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_inc && !ld_lin && !wr_ptr && !wr_ibank && (&st_q.ptr[OFF_W-1:0]))
        |=> (st_q.ptr == {1'b1, {OFF_W{1'b0}}})
         && (st_q.ibank == $past(st_q.ibank) + BANK_W'(1)));

    // R4: direct bank only changes through its own write
    assert_dbank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_dbank |=> $stable(st_q.dbank));

    // R4: indirect bank untouched without its own controls
    assert_ibank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ibank && !ld_lin && !ptr_inc) |=> $stable(st_q.ibank));

    // R9: a write cancels the increment
    assert_write_beats_inc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ptr && !ld_lin) |=> (st_q.ptr == $past(wr_data)));
endmodule

// File: rtl/bam_map.sv
module bam_map
    import bam_pkg::*;
(
    input  logic              acc_ind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  bank_state_t       st,
    output logic [PHYS_W-1:0] phys_addr
);
    logic [ADDR_W-1:0] eff_addr;
    logic [BANK_W-1:0] eff_bank;

    always_comb begin
        eff_addr = acc_ind ? st.ptr   : acc_addr;
        eff_bank = acc_ind ? st.ibank : st.dbank;
        if (eff_addr[OFF_W])
            phys_addr = PHYS_W'(PAGE) + PHYS_W'({eff_bank, eff_addr[OFF_W-1:0]});
        else
            phys_addr = PHYS_W'(eff_addr[OFF_W-1:0]);
    end
endmodule

// File: rtl/bam_top.sv
module bam_top
    import bam_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_ind,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              wr_dbank,
    input  logic              wr_ibank,
    input  logic              wr_ptr,
    input  logic              ld_lin,
    input  logic [LIN_W-1:0]  lin_addr,
    input  logic              ptr_inc,
    output logic [PHYS_W-1:0] phys_addr
);
    bank_state_t st_q;

    bam_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_data  (wr_data),
        .wr_dbank (wr_dbank),
        .wr_ibank (wr_ibank),
        .wr_ptr   (wr_ptr),
        .ld_lin   (ld_lin),
        .lin_addr (lin_addr),
        .ptr_inc  (ptr_inc),
        .st_q     (st_q)
    );

    bam_map u_map (
        .acc_ind   (acc_ind),
        .acc_addr  (acc_addr),
        .st        (st_q),
        .phys_addr (phys_addr)
    );

    // R1: direct accesses below the window never leave the common region
    assert_common_flat_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_ind && !acc_addr[OFF_W]) |-> (phys_addr < PHYS_W'(PAGE)));

    // R2: direct window accesses land past the common region
    assert_window_above_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_ind && acc_addr[OFF_W]) |-> (phys_addr >= PHYS_W'(PAGE)));

    // R3: indirect result does not depend on the direct address input
    assert_ind_ignores_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_ind && $past(acc_ind) && $stable(st_q)) |-> $stable(phys_addr));
endmodule

// File: tb/bam_top_tb.sv
module bam_top_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_ind = 1'b0;
    logic [7:0]  acc_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        wr_dbank = 1'b0, wr_ibank = 1'b0, wr_ptr = 1'b0;
    logic        ld_lin = 1'b0, ptr_inc = 1'b0;
    logic [15:0] lin_addr = '0;
    logic [15:0] phys_addr;

    int vectors = 0;
    int fails   = 0;

    // bench model of the three registers
    logic [7:0] m_dbank = '0, m_ibank = '0, m_ptr = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bam_top u_dut (
        .clk(clk), .rst_n(rst_n), .acc_ind(acc_ind), .acc_addr(acc_addr),
        .wr_data(wr_data), .wr_dbank(wr_dbank), .wr_ibank(wr_ibank),
        .wr_ptr(wr_ptr), .ld_lin(ld_lin), .lin_addr(lin_addr),
        .ptr_inc(ptr_inc), .phys_addr(phys_addr)
    );

    function automatic logic [15:0] expect_phys(input logic ind, input logic [7:0] a,
                                                input logic [7:0] db, input logic [7:0] ib,
                                                input logic [7:0] p);
        logic [7:0] ea;
        logic [7:0] eb;
        ea = ind ? p : a;
        eb = ind ? ib : db;
        if (ea[7]) return 16'd128 + 16'(eb) * 16'd128 + 16'(ea[6:0]);
        return 16'(ea[6:0]);
    endfunction

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: phys_addr actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle();
        wr_dbank = 0; wr_ibank = 0; wr_ptr = 0; ld_lin = 0; ptr_inc = 0;
    endtask

    task automatic model_update();
        if (wr_dbank) m_dbank = wr_data;
        if (ld_lin) begin
            m_ibank = lin_addr[14:7];
            m_ptr   = {1'b1, lin_addr[6:0]};
        end else if (wr_ptr || wr_ibank) begin
            if (wr_ibank) m_ibank = wr_data;
            if (wr_ptr)   m_ptr   = wr_data;
        end else if (ptr_inc) begin
            if (m_ptr[6:0] == 7'h7F) begin
                m_ptr   = 8'h80;
                m_ibank = m_ibank + 8'd1;
            end else begin
                m_ptr[6:0] = m_ptr[6:0] + 7'd1;
            end
        end
    endtask

    // inputs already driven after a negedge: check old-state mapping (R7), clock, update model
    task automatic step(input string tag);
        #1;
        check(tag, phys_addr, expect_phys(acc_ind, acc_addr, m_dbank, m_ibank, m_ptr));
        @(posedge clk);
        model_update();
        @(negedge clk);
        idle();
    endtask

    task automatic access(input string tag, input logic ind, input logic [7:0] a);
        acc_ind = ind; acc_addr = a;
        step(tag);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: actual still running, expected finished");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        // R8: reset state
        repeat (3) @(negedge clk);
        acc_ind = 0; acc_addr = 8'h80; #1;
        check("R8", phys_addr, 16'd128);
        acc_ind = 1; #1;
        check("R8", phys_addr, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        access("R8", 1'b0, 8'h85);

        // R1/R2: common region independent of direct bank
        wr_data = 8'h3C; wr_dbank = 1;
        acc_ind = 0; acc_addr = 8'h12;
        step("R7");                         // same cycle uses old bank
        access("R1", 1'b0, 8'h12);
        access("R2", 1'b0, 8'hC4);
        access("R2", 1'b0, 8'hFF);

        // R4: indirect bank write leaves direct mapping alone
        wr_data = 8'h51; wr_ibank = 1; step("R4");
        access("R4", 1'b0, 8'h9A);
        wr_data = 8'h90; wr_ptr = 1; step("R9");
        access("R3", 1'b1, 8'h00);
        wr_data = 8'h07; wr_dbank = 1; step("R4");
        access("R4", 1'b1, 8'h33);

        // R6: increment with bit 7 clear stays in common region
        wr_data = 8'h05; wr_ptr = 1; step("R9");
        ptr_inc = 1; step("R6");
        access("R6", 1'b1, 8'hAA);
        wr_data = 8'h7F; wr_ptr = 1; step("R9");
        ptr_inc = 1; step("R6");
        access("R6", 1'b1, 8'h00);

        // R5: linear load with top bit set, then bank wrap 255 -> 0
        lin_addr = 16'hFFFF; ld_lin = 1; step("R5");
        access("R5", 1'b1, 8'h00);
        ptr_inc = 1; step("R6");
        access("R6", 1'b1, 8'h00);
        lin_addr = 16'h0ABC; ld_lin = 1; step("R5");
        access("R5", 1'b1, 8'h00);

        // R9: load beats write beats increment
        lin_addr = 16'h1234; ld_lin = 1; wr_ptr = 1; wr_ibank = 1; ptr_inc = 1;
        wr_data = 8'h11; step("R9");
        access("R9", 1'b1, 8'h00);
        wr_data = 8'h22; wr_ibank = 1; ptr_inc = 1; step("R9");
        access("R9", 1'b1, 8'h00);

        // constrained random
        for (int n = 0; n < 4000; n++) begin
            acc_ind  = 1'($urandom % 2);
            acc_addr = 8'($urandom);
            wr_data  = 8'($urandom);
            lin_addr = 16'($urandom);
            wr_dbank = ($urandom % 6) == 0;
            wr_ibank = ($urandom % 8) == 0;
            wr_ptr   = ($urandom % 8) == 0;
            ld_lin   = ($urandom % 10) == 0;
            ptr_inc  = ($urandom % 3) == 0;
            step(acc_ind ? "R3" : (acc_addr[7] ? "R2" : "R1"));
        end
        summary();
    end
endmodule